// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block converts raw external interrupt pins into interrupt requests for a small processor core. It has a parameterised number of general sense channels and one extra edge-only channel. Each general channel can be set to react to a low level, to any logical change, to a falling edge or to a rising edge. The edge-only channel reacts to one edge direction, chosen by a single polarity bit. Every pin passes through a synchroniser before detection.

Edge events set a per-channel flag. The core clears a flag in one of two ways: it writes a one to the flag's clear strobe, or it acknowledges that channel. Low-level mode has no flag; the request simply follows the synchronised pin. A request reaches the core only when both the global enable and the channel's mask bit are high. The sense fields and the polarity bit sit in a single configuration word, which is written in one cycle.

Top module: `extint_ctrl`

## Requirements
- R1: The configuration word holds the sense field of general channel i at bits [2i+1:2i] and the edge-only polarity at bit 2*NUM_SENSE. Sense encoding: 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. After reset every field is 00, every flag is 0, and every general channel is in low-level mode.
- R2: `irq_o[i]` is high only while `gie_i` and `mask_i[i]` are both high. A flag still latches while its mask bit is low, and it raises the request as soon as the mask is set.
- R3: In low-level mode the request follows the synchronised pin: it is high while the pin is low. The flag stays 0, and the request drops when the pin returns high, with nothing latched.
- R4: In any-change mode both a rising and a falling transition set the flag. A pin that does not change sets nothing.
- R5: Falling mode sets the flag only on a 1-to-0 transition. Rising mode sets it only on a 0-to-1 transition.
- R6: With SYNC_STAGES=2, a pin change driven before clock edge k sets the flag at edge k+2, so the flag is visible from edge k+2 onward. A pulse that holds for one full clock period produces a detected edge.
- R7: A one on `flag_clr_i[i]` clears flag i at the next edge. A zero on that bit has no effect.
- R8: A one on `ack_i[i]` clears flag i at the next edge.
- R9: When a clear strobe and a new edge event fall in the same cycle, the edge wins and the flag stays set.
- R10: On the edge-only channel (index NUM_SENSE), polarity 0 selects falling edges and polarity 1 selects rising edges. The other direction sets nothing.
- R11: Changing the polarity to the direction whose active level the pin already shows (for example, pin high with polarity going 0 to 1) sets the edge-only flag. Changing it to the other direction does not.
- R12: A pin that is held high through reset causes no flag and no request once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_SENSE+1 | Raw interrupt pins; the top index is the edge-only channel |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 2*NUM_SENSE+1 | Sense fields and edge-only polarity |
| gie_i | input | 1 | Global interrupt enable |
| mask_i | input | NUM_SENSE+1 | Per-channel mask bits |
| flag_clr_i | input | NUM_SENSE+1 | Per-channel write-one-to-clear strobes |
| ack_i | input | NUM_SENSE+1 | Per-channel acknowledge from the core |
| irq_o | output | NUM_SENSE+1 | Gated interrupt requests |
| flag_o | output | NUM_SENSE+1 | Latched edge flags |

## Verification
The bench builds the block with its defaults, NUM_SENSE=2 and SYNC_STAGES=2. That gives two general channels and the edge-only channel at index 2, so the exact three-edge latency from pin to flag can be checked cycle by cycle. With two general channels, one channel can run through all four sense modes while the other stays quiet in low-level mode with its pin high. The edge-only channel tests polarity switching with the pin held at each level.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_i,
    output logic sync_o,
    output logic prev_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    // History register always tracks the synchronised value, so during reset
    // it already equals the current pin level and no false edge appears.
    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[LAST];
    assign prev_o = st_q.prev;

endmodule

// File: rtl/extint_sense_chan.sv
module extint_sense_chan
    import extint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sense_mode_e mode_i,
    input  logic        sync_i,
    input  logic        prev_i,
    input  logic        clr_i,
    input  logic        ack_i,
    output logic        req_o,
    output logic        flag_o
);
    typedef struct packed {
        logic flag;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        rise_w;
    logic        fall_w;
    logic        evt_w;

    always_comb begin
        rise_w = sync_i & ~prev_i;
        fall_w = ~sync_i & prev_i;
        unique case (mode_i)
            SENSE_ANY:  evt_w = rise_w | fall_w;
            SENSE_FALL: evt_w = fall_w;
            SENSE_RISE: evt_w = rise_w;
            default:    evt_w = 1'b0;
        endcase

        st_d = st_q;
        if (!rst_n || mode_i == SENSE_LOW) begin
            st_d.flag = 1'b0;
        end else begin
            // a fresh event outranks a clear in the same cycle
            st_d.flag = evt_w | (st_q.flag & ~clr_i & ~ack_i);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req_o  = (mode_i == SENSE_LOW) ? ~sync_i : st_q.flag;
    assign flag_o = st_q.flag;

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w |=> st_q.flag);  // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && clr_i && !evt_w) |=> !st_q.flag);  // R7

    AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && ack_i && !evt_w) |=> !st_q.flag);  // R8

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_i == SENSE_LOW) |-> !st_q.flag);  // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i && !ack_i && mode_i != SENSE_LOW) |=> st_q.flag);  // R4

endmodule

// File: rtl/extint_edge_chan.sv
module extint_edge_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_i,
    input  logic sync_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic req_o,
    output logic flag_o
);
    typedef struct packed {
        logic act_prev;
        logic flag;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        act_w;
    logic        evt_w;

    // act_w is high when the pin shows the level the selected edge leads to;
    // a polarity change alters it as well, which can raise an event by itself.
    always_comb begin
        act_w = pol_i ? sync_i : ~sync_i;
        evt_w = act_w & ~st_q.act_prev;

        st_d          = st_q;
        st_d.act_prev = act_w;
        if (!rst_n) begin
            st_d.flag = 1'b0;
        end else begin
            st_d.flag = evt_w | (st_q.flag & ~clr_i & ~ack_i);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req_o  = st_q.flag;
    assign flag_o = st_q.flag;

    AST_POL_SWITCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pol_i) && pol_i && sync_i && $past(sync_i)) |=> st_q.flag);  // R11

    AST_EDGE_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w && clr_i) |=> st_q.flag);  // R9

    AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && (clr_i || ack_i) && !evt_w) |=> !st_q.flag);  // R7

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_SENSE   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SENSE:0]     pin_i,
    input  logic                   cfg_we_i,
    input  logic [2*NUM_SENSE:0]   cfg_wdata_i,
    input  logic                   gie_i,
    input  logic [NUM_SENSE:0]     mask_i,
    input  logic [NUM_SENSE:0]     flag_clr_i,
    input  logic [NUM_SENSE:0]     ack_i,
    output logic [NUM_SENSE:0]     irq_o,
    output logic [NUM_SENSE:0]     flag_o
);
    localparam int NUM_CH  = NUM_SENSE + 1;
    localparam int CFG_W   = 2 * NUM_SENSE + 1;
    localparam int POL_BIT = CFG_W - 1;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [NUM_CH-1:0] sync_w;
    logic [NUM_CH-1:0] prev_w;
    logic [NUM_CH-1:0] req_w;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cfg = '0;
        end else if (cfg_we_i) begin
            st_d.cfg = cfg_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
        extint_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk    (clk),
            .pin_i  (pin_i[c]),
            .sync_o (sync_w[c]),
            .prev_o (prev_w[c])
        );
    end

    for (genvar c = 0; c < NUM_SENSE; c++) begin : g_sense
        extint_sense_chan chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (sense_mode_e'(st_q.cfg[2*c +: 2])),
            .sync_i (sync_w[c]),
            .prev_i (prev_w[c]),
            .clr_i  (flag_clr_i[c]),
            .ack_i  (ack_i[c]),
            .req_o  (req_w[c]),
            .flag_o (flag_o[c])
        );
    end

    extint_edge_chan edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pol_i  (st_q.cfg[POL_BIT]),
        .sync_i (sync_w[NUM_SENSE]),
        .clr_i  (flag_clr_i[NUM_SENSE]),
        .ack_i  (ack_i[NUM_SENSE]),
        .req_o  (req_w[NUM_SENSE]),
        .flag_o (flag_o[NUM_SENSE])
    );

    // prev_w is unused on the edge-only channel; it keeps its own history
    logic unused_prev;
    assign unused_prev = prev_w[NUM_SENSE];

    assign irq_o = req_w & mask_i & {NUM_CH{gie_i}};

    AST_CFG_RESET_ZERO: assert property (@(posedge clk)
        $past(!rst_n) |-> (st_q.cfg == '0));  // R1

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (st_q.cfg == $past(cfg_wdata_i)));  // R1

endmodule

// File: tb/extint_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
    localparam int NS = 2;
    localparam int NC = NS + 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NC-1:0]   pin;
    logic            cfg_we;
    logic [2*NS:0]   cfg_wdata;
    logic            gie;
    logic [NC-1:0]   mask;
    logic [NC-1:0]   clr;
    logic [NC-1:0]   ack;
    logic [NC-1:0]   irq;
    logic [NC-1:0]   flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    extint_ctrl #(.NUM_SENSE(NS), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .gie_i       (gie),
        .mask_i      (mask),
        .flag_clr_i  (clr),
        .ack_i       (ack),
        .irq_o       (irq),
        .flag_o      (flag)
    );

    // {mode[1:0], pin before, pin after, expected flag, expected irq} for channel 0
    localparam logic [5:0] VEC [0:11] = '{
        6'b00_1_0_0_1, 6'b00_0_1_0_0, 6'b00_1_1_0_0,
        6'b01_0_1_1_1, 6'b01_1_0_1_1, 6'b01_1_1_0_0,
        6'b10_1_0_1_1, 6'b10_0_1_0_0, 6'b10_1_1_0_0,
        6'b11_0_1_1_1, 6'b11_1_0_0_0, 6'b11_0_0_0_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [2*NS:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic clear_all();
        clr = '1;
        @(negedge clk);
        clr = '0;
    endtask

    initial begin
        rst_n = 1'b0; pin = '1; cfg_we = 1'b0; cfg_wdata = '0;
        gie = 1'b0; mask = '0; clr = '0; ack = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk("R12 flags after reset", 32'(flag), 0);
        chk("R12 irq after reset", 32'(irq), 0);
        gie = 1'b1; mask = '1;
        cyc(2);
        chk("R12 no request with pins high", 32'(irq), 0);
        pin[0] = 1'b0;
        cyc(3);
        chk("R1 reset mode is low level", 32'(irq[0]), 1);
        chk("R1 low level keeps flag clear", 32'(flag[0]), 0);
        pin[0] = 1'b1;
        cyc(3);

        for (int i = 0; i < 12; i++) begin
            logic [5:0] v;
            string tg;
            v  = VEC[i];
            tg = (v[5:4] == 2'b00) ? "R1 R3" : (v[5:4] == 2'b01) ? "R1 R4" : "R1 R5";
            write_cfg({1'b0, 2'b00, v[5:4]});
            pin[0] = v[3];
            cyc(4);
            clear_all();
            pin[0] = v[2];
            cyc(4);
            chk($sformatf("%s vec%0d flag", tg, i), 32'(flag[0]), 32'(v[1]));
            chk($sformatf("%s vec%0d irq", tg, i), 32'(irq[0]), 32'(v[0]));
        end

        // channel 1 in any-change mode; pin1 is high
        write_cfg({1'b0, 2'b01, 2'b00});
        pin[0] = 1'b1;
        cyc(3);
        clear_all();
        pin[1] = 1'b0;
        cyc(2);
        chk("R6 flag not yet set", 32'(flag[1]), 0);
        cyc(1);
        chk("R6 flag set after third edge", 32'(flag[1]), 1);
        clear_all();
        chk("R7 cleared before same-cycle test", 32'(flag[1]), 0);
        pin[1] = 1'b1;
        cyc(2);
        clr = 3'b010;
        @(negedge clk);
        clr = '0;
        chk("R9 edge beats clear", 32'(flag[1]), 1);
        clr = 3'b101;
        @(negedge clk);
        clr = '0;
        chk("R7 zero bit leaves flag", 32'(flag[1]), 1);
        clr = 3'b010;
        @(negedge clk);
        clr = '0;
        chk("R7 one bit clears flag", 32'(flag[1]), 0);

        mask = 3'b101;
        pin[1] = 1'b0;
        cyc(4);
        chk("R2 flag latches while masked", 32'(flag[1]), 1);
        chk("R2 masked request low", 32'(irq[1]), 0);
        mask = 3'b111;
        cyc(1);
        chk("R2 unmask raises request", 32'(irq[1]), 1);
        gie = 1'b0;
        cyc(1);
        chk("R2 global enable gates request", 32'(irq[1]), 0);
        gie = 1'b1;
        ack = 3'b010;
        @(negedge clk);
        ack = '0;
        chk("R8 ack clears flag", 32'(flag[1]), 0);
        chk("R8 ack drops request", 32'(irq[1]), 0);

        pin[1] = 1'b1;
        @(negedge clk);
        pin[1] = 1'b0;
        cyc(4);
        chk("R6 one-period pulse detected", 32'(flag[1]), 1);
        clear_all();

        // edge-only channel, polarity 0 (falling)
        pin[2] = 1'b0;
        cyc(4);
        chk("R10 falling with polarity 0", 32'(flag[2]), 1);
        chk("R10 request raised", 32'(irq[2]), 1);
        clear_all();
        pin[2] = 1'b1;
        cyc(4);
        chk("R10 rising ignored with polarity 0", 32'(flag[2]), 0);

        write_cfg({1'b1, 2'b01, 2'b00});
        cyc(2);
        chk("R11 polarity switch with pin high sets flag", 32'(flag[2]), 1);
        clear_all();
        cyc(2);
        chk("R11 no repeat after clear", 32'(flag[2]), 0);
        pin[2] = 1'b0;
        cyc(4);
        chk("R10 falling ignored with polarity 1", 32'(flag[2]), 0);
        pin[2] = 1'b1;
        cyc(4);
        chk("R10 rising with polarity 1", 32'(flag[2]), 1);
        clear_all();
        write_cfg({1'b0, 2'b01, 2'b00});
        cyc(3);
        chk("R11 switch away from pin level sets nothing", 32'(flag[2]), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule